// File: doc/BRIEF.md
# Pipelined Byte-Lane Memory Slave

This block is the memory side of a pipelined processor bus. It holds a small RAM and serves byte, halfword and word transfers, both as single accesses and as sequential bursts. The master presents a request (valid, byte address, size, direction, sequential flag, lock) one cycle before the data phase of that request. It drives write data during the data phase. Read data comes back in the cycle after the data phase.

The size and the low address bits select which byte lanes a write touches. Redundant low bits are ignored: both for a word, bit 0 for a halfword. Narrow reads are repeated across all four lanes, so the master can take any lane. The block also checks the bus rules. It flags a reserved size code, a sequential request that breaks the burst, and an atomic read/write pair that is split or incomplete. Each flag is a one-cycle pulse in the data phase of the offending request.

Top module: `lane_mem_slave`

## Requirements
- R1: While reset is high and in the first cycle after it, `rvalid`, `size_err`, `burst_err` and `lock_err` are low.
- R2: A request sampled at clock edge E has its write data sampled at edge E+1. For a read, `rvalid` and `rdata` are valid in the cycle after edge E+1. A read that directly follows a write to the same word returns the new data.
- R3: Size code 2'b10 is a word. It reads or writes all four lanes of word `addr[AW+1:2]`, and `addr[1:0]` is ignored.
- R4: Size code 2'b01 is a halfword, and `addr[0]` is ignored. With `addr[1]`=0 it writes lanes 0 and 1 (`wdata[15:0]`). With `addr[1]`=1 it writes lanes 2 and 3 (`wdata[31:16]`). A halfword read returns the selected 16 bits twice.
- R5: Size code 2'b00 is a byte. It writes only lane `addr[1:0]` (`wdata[8n+7:8n]`), and the other bytes of the word are unchanged. A byte read returns the byte four times.
- R6: Size code 2'b11 is reserved. It writes nothing and raises no `rvalid`, and `size_err` pulses in its data phase.
- R7: A sequential request (`req_seq`=1) whose direction differs from the previous request raises `burst_err` in its data phase.
- R8: A sequential request raises `burst_err` if its address is not the previous request's address plus 1, 2 or 4 bytes (for the previous size 00, 01 or 10), or if no request has been seen since reset.
- R9: A locked read (`req_lock`=1, read) must be followed by a locked write to the same address as the next request. Any other next request raises `lock_err`. A locked write that does not follow a locked read also raises `lock_err`.
- R10: Address bits above `addr[AW+1:2]` are ignored, so the RAM repeats through the address space.
- R11: A request that raises `burst_err` or `lock_err` still performs its transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle (address phase) |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word, 11 reserved |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seq | input | 1 | Request continues the previous one as a burst |
| req_lock | input | 1 | Part of an atomic read/write pair |
| wdata | input | 32 | Write data, valid in the data phase |
| rdata | output | 32 | Read data, lane-replicated for narrow reads |
| rvalid | output | 1 | `rdata` valid this cycle |
| size_err | output | 1 | Reserved size pulse |
| burst_err | output | 1 | Burst rule violation pulse |
| lock_err | output | 1 | Atomic pair violation pulse |

## Verification
The hardest case to reach is the overlap of two pipelined requests on one word: a write in its data phase while a read of the same word is in its address phase. A partial-lane write also has to be shown to leave its neighbours untouched. The stimulus issues back-to-back write/read pairs to one address, and narrow writes whose unused lanes carry filler data. It then reads the whole word back. A long random mix of sizes, directions, sequential flags and lock requests runs against a byte-array model that holds every stored byte, so any lane or timing slip shows up in a later read.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lms_pkg::*;
(
  input  xfer_size_e         size,
  input  logic [1:0]         off,
  output logic [LANES-1:0]   lanes
);
  // Little-endian: byte offset n maps to lane n.
  always_comb begin
    lanes = '0;
    case (size)
      SZ_BYTE: lanes[off] = 1'b1;
      SZ_HALF: lanes = off[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: lanes = 4'b1111;
      default: lanes = '0;
    endcase
  end
endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wbyte,
  output logic [7:0]    rbyte
);
  logic [7:0] mem [DEPTH];

  // Single-port, synchronous read: maps onto one block RAM per lane.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wbyte;
    if (re) rbyte <= mem[idx];
  end
endmodule

// File: rtl/read_align.sv
module read_align
  import lms_pkg::*;
(
  input  xfer_size_e         size,
  input  logic [1:0]         off,
  input  logic [DATA_W-1:0]  word,
  output logic [DATA_W-1:0]  data
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = word[{off, 3'b000} +: 8];
    sel_h = off[1] ? word[31:16] : word[15:0];
    case (size)
      SZ_BYTE: data = {LANES{sel_b}};
      SZ_HALF: data = {2{sel_h}};
      default: data = word;
    endcase
  end
endmodule

// File: rtl/bus_rules.sv
module bus_rules
  import lms_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_seq,
  input  logic              req_lock,
  output logic              size_err,
  output logic              burst_err,
  output logic              lock_err
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              prev_v, prev_wr, lock_pend;
  logic [1:0]        prev_size;
  logic [ADDR_W-1:0] prev_addr, lock_addr, next_addr;
  logic              seq_bad, lock_bad;

  assign next_addr = prev_addr + (ONE << prev_size);

  always_comb begin
    seq_bad  = req_seq && (!prev_v || (prev_wr != req_write) || (req_addr != next_addr));
    lock_bad = lock_pend ? !(req_lock && req_write && (req_addr == lock_addr))
                         : (req_lock && req_write);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_v    <= 1'b0;
      lock_pend <= 1'b0;
      size_err  <= 1'b0;
      burst_err <= 1'b0;
      lock_err  <= 1'b0;
    end else begin
      size_err  <= req_valid && (xfer_size_e'(req_size) == SZ_RSVD);
      burst_err <= req_valid && seq_bad;
      lock_err  <= req_valid && lock_bad;
      if (req_valid) begin
        prev_v    <= 1'b1;
        lock_pend <= req_lock && !req_write;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      prev_wr   <= req_write;
      prev_size <= req_size;
      prev_addr <= req_addr;
      lock_addr <= req_addr;
    end
  end

  // R7 / R8: a burst fault only follows a sequential request
  a_r7_burst_err_on_seq: assert property (@(posedge clk) disable iff (rst)
    burst_err |-> $past(req_valid && req_seq));
  // R9: a lock fault only follows a request
  a_r9_lock_err_on_req: assert property (@(posedge clk) disable iff (rst)
    lock_err |-> $past(req_valid));
  // R6: size fault only for the reserved code
  a_r6_size_err_rsvd: assert property (@(posedge clk) disable iff (rst)
    size_err |-> ($past(req_size) == 2'b11));
  // R9: a locked read followed at once by its matching locked write is clean
  a_r9_pair_clean: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lock && !req_write) ##1
    (req_valid && req_lock && req_write && req_addr == $past(req_addr)) |=> !lock_err);
endmodule

// File: rtl/lane_mem_slave.sv
module lane_mem_slave
  import lms_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_seq,
  input  logic              req_lock,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              size_err,
  output logic              burst_err,
  output logic              lock_err
);
  localparam int AW = $clog2(DEPTH);

  xfer_size_e         req_sz_e;
  logic [LANES-1:0]   req_lanes;

  // Data-phase registers (request captured one cycle earlier)
  logic               a_vld, a_wr;
  logic [AW-1:0]      a_idx;
  logic [LANES-1:0]   a_lanes;
  xfer_size_e         a_size;
  logic [1:0]         a_off;

  // Read-return registers
  logic               b_vld;
  xfer_size_e         b_size;
  logic [1:0]         b_off;
  logic [DATA_W-1:0]  ram_q;

  assign req_sz_e = xfer_size_e'(req_size);

  lane_decode u_dec (
    .size  (req_sz_e),
    .off   (req_addr[1:0]),
    .lanes (req_lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld <= 1'b0;
      b_vld <= 1'b0;
    end else begin
      a_vld <= req_valid && (req_sz_e != SZ_RSVD);
      b_vld <= a_vld && !a_wr;
    end
  end

  always_ff @(posedge clk) begin
    a_wr    <= req_write;
    a_idx   <= req_addr[AW+1:2];
    a_lanes <= req_lanes;
    a_size  <= req_sz_e;
    a_off   <= req_addr[1:0];
    b_size  <= a_size;
    b_off   <= a_off;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_lane_ram #(.DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (a_vld && a_wr && a_lanes[g]),
      .re    (a_vld && !a_wr),
      .idx   (a_idx),
      .wbyte (wdata[8*g +: 8]),
      .rbyte (ram_q[8*g +: 8])
    );
  end

  read_align u_align (
    .size (b_size),
    .off  (b_off),
    .word (ram_q),
    .data (rdata)
  );

  assign rvalid = b_vld;

  bus_rules #(.ADDR_W(ADDR_W)) u_rules (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_write (req_write),
    .req_seq   (req_seq),
    .req_lock  (req_lock),
    .size_err  (size_err),
    .burst_err (burst_err),
    .lock_err  (lock_err)
  );

  // R2: read data returns two edges after a non-reserved read request
  a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(req_valid && !req_write && req_size != 2'b11, 2));
  // R6: reserved size never reaches the RAM
  a_r6_no_access_rsvd: assert property (@(posedge clk) disable iff (rst)
    a_vld |-> ($past(req_size) != 2'b11));
  // R5: a byte access touches exactly one lane
  a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
    (a_vld && a_size == SZ_BYTE) |-> ($countones(a_lanes) == 1));
  // R4: a halfword access touches an aligned lane pair
  a_r4_half_pair: assert property (@(posedge clk) disable iff (rst)
    (a_vld && a_size == SZ_HALF) |-> (a_lanes == 4'b0011 || a_lanes == 4'b1100));
  // R3: a word access touches all lanes
  a_r3_word_all: assert property (@(posedge clk) disable iff (rst)
    (a_vld && a_size == SZ_WORD) |-> (a_lanes == 4'b1111));
endmodule

// File: tb/test_lane_mem_slave.sv
`timescale 1ns/1ps
module test_lane_mem_slave;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0, req_seq = 1'b0, req_lock = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, size_err, burst_err, lock_err;

  int    nchk = 0;
  int    nerr = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";
  logic [31:0] nxt_wd = '0;

  always #4 clk = ~clk;  // 125 MHz

  lane_mem_slave i_lane_mem_slave (
    .clk, .rst, .req_valid, .req_addr, .req_size, .req_write, .req_seq,
    .req_lock, .wdata, .rdata, .rvalid, .size_err, .burst_err, .lock_err
  );

  // ---------------- reference model ----------------
  logic [7:0]  mm [DEPTH*4];
  logic        e_rv = 0, e_se = 0, e_be = 0, e_le = 0;
  logic [31:0] e_rd = '0;
  logic        dp_v = 0, dp_w = 0;
  logic [31:0] dp_a = '0;
  logic [1:0]  dp_s = '0;
  logic        pv = 0, pw = 0, pend = 0;
  logic [31:0] pa = '0, pend_a = '0;
  logic [1:0]  ps = '0;

  function automatic int wbase(logic [31:0] a);
    return int'((a >> 2) & (DEPTH - 1)) * 4;
  endfunction

  function automatic bit lane_on(logic [1:0] sz, logic [31:0] a, int l);
    case (sz)
      2'b00:   return l == int'(a[1:0]);
      2'b01:   return (l / 2) == int'(a[1]);
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mread(logic [31:0] a, logic [1:0] sz);
    int b = wbase(a);
    logic [15:0] h;
    case (sz)
      2'b00: return {4{mm[b + int'(a[1:0])]}};
      2'b01: begin
        h = a[1] ? {mm[b+3], mm[b+2]} : {mm[b+1], mm[b]};
        return {2{h}};
      end
      default: return {mm[b+3], mm[b+2], mm[b+1], mm[b]};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_rv = 0; e_se = 0; e_be = 0; e_le = 0;
      dp_v = 0; pv = 0; pend = 0;
    end else begin
      e_rv = 0;
      if (dp_v && dp_s != 2'b11) begin
        if (dp_w) begin
          for (int l = 0; l < 4; l++)
            if (lane_on(dp_s, dp_a, l)) mm[wbase(dp_a) + l] = wdata[8*l +: 8];
        end else begin
          e_rv = 1;
          e_rd = mread(dp_a, dp_s);
        end
      end
      e_se = 0; e_be = 0; e_le = 0;
      if (req_valid) begin
        e_se = (req_size == 2'b11);
        if (req_seq)
          e_be = !pv || (req_write != pw) || (req_addr != pa + (32'd1 << ps));
        if (pend) e_le = !(req_lock && req_write && req_addr == pend_a);
        else      e_le = req_lock && req_write;
        pend = req_lock && !req_write;
        pend_a = req_addr;
        pv = 1; pw = req_write; pa = req_addr; ps = req_size;
      end
      dp_v = req_valid; dp_w = req_write; dp_a = req_addr; dp_s = req_size;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("rvalid",    {31'd0, rvalid},    {31'd0, e_rv});
      chk("size_err",  {31'd0, size_err},  {31'd0, e_se});
      chk("burst_err", {31'd0, burst_err}, {31'd0, e_be});
      chk("lock_err",  {31'd0, lock_err},  {31'd0, e_le});
      if (e_rv) chk("rdata", rdata, e_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input logic v, input logic [31:0] a, input logic [1:0] sz,
                      input logic w, input logic s, input logic lk, input logic [31:0] d);
    @(negedge clk);
    req_valid = v; req_addr = a; req_size = sz;
    req_write = w; req_seq = s; req_lock = lk;
    wdata = nxt_wd; nxt_wd = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) xfer(0, 32'd0, 2'b00, 0, 0, 0, 32'd0);
  endtask

  initial begin
    // R1: outputs low during reset
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("reset rvalid",    {31'd0, rvalid},    32'd0);
    chk("reset size_err",  {31'd0, size_err},  32'd0);
    chk("reset burst_err", {31'd0, burst_err}, 32'd0);
    chk("reset lock_err",  {31'd0, lock_err},  32'd0);
    rst = 1'b0;

    // R8 / R11: sequential request with no history flags but still writes
    cur_tag = "R8 R11";
    xfer(1, 32'h0, 2'b10, 1, 1, 0, 32'h0BAD_F00D);
    // R3 / R7: fill memory with one legal write burst
    cur_tag = "R3 R7";
    for (int i = 0; i < DEPTH; i++)
      xfer(1, i * 4, 2'b10, 1, i != 0, 0, {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A, 8'h3C});
    idle(2);
    // R3: word reads ignore addr[1:0]
    for (int k = 0; k < 4; k++) xfer(1, 32'h14 + k, 2'b10, 0, 0, 0, 0);
    idle(2);
    // R2: write then immediate read of the same word, then a read burst
    cur_tag = "R2";
    xfer(1, 32'h30, 2'b10, 1, 0, 0, 32'h1234_5678);
    xfer(1, 32'h30, 2'b10, 0, 0, 0, 0);
    xfer(1, 32'h34, 2'b10, 0, 1, 0, 0);
    xfer(1, 32'h38, 2'b10, 0, 1, 0, 0);
    idle(2);
    // R4: halfword lanes, bit 0 ignored
    cur_tag = "R4";
    xfer(1, 32'h40, 2'b01, 1, 0, 0, 32'h1111_BEEF);
    xfer(1, 32'h43, 2'b01, 1, 0, 0, 32'hCAFE_2222);
    xfer(1, 32'h40, 2'b10, 0, 0, 0, 0);
    xfer(1, 32'h41, 2'b01, 0, 0, 0, 0);
    xfer(1, 32'h42, 2'b01, 0, 0, 0, 0);
    idle(2);
    // R5: byte lanes, filler on other lanes must not land
    cur_tag = "R5";
    for (int n = 0; n < 4; n++)
      xfer(1, 32'h80 + n, 2'b00, 1, 0, 0,
           (32'hEEEE_EEEE & ~(32'hFF << (8*n))) | ((32'h10 + n) << (8*n)));
    for (int n = 0; n < 4; n++) xfer(1, 32'h80 + n, 2'b00, 0, 0, 0, 0);
    xfer(1, 32'h80, 2'b10, 0, 0, 0, 0);
    idle(2);
    // R6: reserved size writes nothing, no read return
    cur_tag = "R6";
    xfer(1, 32'h80, 2'b11, 1, 0, 0, 32'h0);
    xfer(1, 32'h80, 2'b11, 0, 0, 0, 0);
    xfer(1, 32'h80, 2'b10, 0, 0, 0, 0);
    idle(2);
    // R7 / R11: direction change inside a burst
    cur_tag = "R7 R11";
    xfer(1, 32'hC0, 2'b10, 1, 0, 0, 32'hAAAA_0001);
    xfer(1, 32'hC4, 2'b10, 0, 1, 0, 0);
    xfer(1, 32'hC8, 2'b10, 1, 1, 0, 32'hAAAA_0003);
    idle(2);
    // R8: burst address steps by size
    cur_tag = "R8";
    xfer(1, 32'hD0, 2'b10, 1, 0, 0, 32'h5555_0000);
    xfer(1, 32'hD8, 2'b10, 1, 1, 0, 32'h5555_0001);
    xfer(1, 32'hE0, 2'b00, 0, 0, 0, 0);
    xfer(1, 32'hE1, 2'b00, 0, 1, 0, 0);
    xfer(1, 32'hE2, 2'b01, 0, 1, 0, 0);
    xfer(1, 32'hE4, 2'b01, 0, 1, 0, 0);
    xfer(1, 32'hE8, 2'b01, 0, 1, 0, 0);
    idle(2);
    // R9: atomic pairs
    cur_tag = "R9";
    xfer(1, 32'h100, 2'b10, 0, 0, 1, 0);
    xfer(1, 32'h100, 2'b10, 1, 0, 1, 32'h7777_0000);
    xfer(1, 32'h104, 2'b10, 0, 0, 1, 0);
    xfer(1, 32'h108, 2'b10, 0, 0, 0, 0);
    xfer(1, 32'h10C, 2'b10, 1, 0, 1, 32'h7777_000C);
    xfer(1, 32'h110, 2'b10, 0, 0, 1, 0);
    idle(1);
    xfer(1, 32'h114, 2'b10, 1, 0, 1, 32'h7777_0014);
    xfer(1, 32'h100, 2'b10, 0, 0, 0, 0);
    idle(2);
    // R10: upper address bits alias
    cur_tag = "R10";
    xfer(1, 32'hF000_0020, 2'b10, 1, 0, 0, 32'hA1A5_5A1A);
    xfer(1, 32'h0000_0020, 2'b10, 0, 0, 0, 0);
    xfer(1, 32'h0000_0000 + DEPTH * 4 + 32'h24, 2'b10, 0, 0, 0, 0);
    idle(2);
    // Random mix of every size, direction, burst and lock case
    cur_tag = "R3 R4 R5 R6 R7 R8 R9 random";
    for (int i = 0; i < 4000; i++)
      xfer(($urandom % 4) != 0, $urandom, 2'($urandom % 4), 1'($urandom % 2),
           1'($urandom % 2), ($urandom % 8) == 0, $urandom);
    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule